// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block picks the address of the next microinstruction in a microcoded controller. A 4-bit state register holds the current microinstruction number. A small per-state table gives each state a 2-bit next-address selector. The selector chooses one of four sources for the next state:

- go back to state 0;
- look up the opcode in the first dispatch table;
- look up the opcode in the second dispatch table;
- add one to the current state.

The 6-bit opcode of the instruction being executed takes part only through the two dispatch tables.

The block is used next to a control-word store that is indexed by the same state number. That store is not part of this block. Each clock edge moves the controller one microstep. A synchronous reset starts it again at the fetch state 0. The selector in use is brought out so that the sequencing decision can be observed.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state_num` becomes 0 after that edge, whatever the opcode.
- R2: `sel_dbg` shows the selector of the current state. States 0, 3 and 6 give 3. State 1 gives 1. State 2 gives 2. Every other state (4, 5, 7 to 15) gives 0.
- R3: With selector 3 (step), the next state is the current state plus one.
- R4: With selector 0 (restart), the next state is 0.
- R5: With selector 1, the next state comes from the first table:
  - opcode 6'b000000 gives 6;
  - opcode 6'b000010 gives 9;
  - opcode 6'b000100 gives 8;
  - opcodes 6'b100011 and 6'b101011 give 2.
- R6: With selector 2, the next state comes from the second table: opcode 6'b100011 gives 3 and opcode 6'b101011 gives 5.
- R7: An opcode that is not listed in the table being consulted leads to state 0.
- R8: Holding one opcode from reset produces these state sequences:
  - 6'b000000: 0,1,6,7,0;
  - 6'b100011: 0,1,2,3,4,0;
  - 6'b101011: 0,1,2,5,0;
  - 6'b000100: 0,1,8,0;
  - 6'b000010: 0,1,9,0.
- R9: In states whose selector is 0 or 3, the opcode has no effect on the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous reset to state 0, active high |
| opcode | input | 6 | Opcode field of the instruction being executed |
| state_num | output | 4 | Current microinstruction number |
| sel_dbg | output | 2 | Next-address selector of the current state |

## Verification
`sel_dbg` depends only on the current state, so it is valid in the same cycle as `state_num`. The next state appears on `state_num` one rising edge after the opcode and selector that produced it. The bench drives `opcode` and `rst` on the falling edge and samples both outputs on the following falling edge. Each sample is compared with a reference state that the bench advances once per edge. Directed runs compare whole sequences nibble by nibble from the cycle that follows reset.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ST_W = 4;
  localparam int OP_W = 6;

  typedef logic [ST_W-1:0] ustate_t;
  typedef logic [OP_W-1:0] op_t;

  typedef enum logic [1:0] {
    SEL_RESTART = 2'd0,
    SEL_TBL1    = 2'd1,
    SEL_TBL2    = 2'd2,
    SEL_STEP    = 2'd3
  } sel_e;

  // Selector stored for each microstate.
  function automatic sel_e field_of(ustate_t s);
    case (s)
      4'd0, 4'd3, 4'd6: field_of = SEL_STEP;
      4'd1:             field_of = SEL_TBL1;
      4'd2:             field_of = SEL_TBL2;
      default:          field_of = SEL_RESTART;
    endcase
  endfunction

  // First dispatch: instruction class entry point.
  function automatic ustate_t tbl1_of(op_t op);
    case (op)
      6'b000000: tbl1_of = 4'd6;
      6'b000010: tbl1_of = 4'd9;
      6'b000100: tbl1_of = 4'd8;
      6'b100011: tbl1_of = 4'd2;
      6'b101011: tbl1_of = 4'd2;
      default:   tbl1_of = 4'd0;
    endcase
  endfunction

  // Second dispatch: memory read or memory write path.
  function automatic ustate_t tbl2_of(op_t op);
    case (op)
      6'b100011: tbl2_of = 4'd3;
      6'b101011: tbl2_of = 4'd5;
      default:   tbl2_of = 4'd0;
    endcase
  endfunction

  function automatic ustate_t step_of(ustate_t s);
    step_of = s + ustate_t'(1);
  endfunction
endpackage

// File: rtl/useq_ctl_field.sv
module useq_ctl_field
  import useq_pkg::*;
(
  input  ustate_t cur,
  output sel_e    sel
);
  always_comb sel = field_of(cur);
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int TABLE_SEL = 1
) (
  input  op_t     op,
  output ustate_t target
);
  generate
    if (TABLE_SEL == 1) begin : g_first
      always_comb target = tbl1_of(op);
    end else begin : g_second
      always_comb target = tbl2_of(op);
    end
  endgenerate
endmodule

// File: rtl/useq_next_mux.sv
module useq_next_mux
  import useq_pkg::*;
(
  input  sel_e    sel,
  input  ustate_t cur,
  input  ustate_t tgt1,
  input  ustate_t tgt2,
  output ustate_t nxt
);
  always_comb begin
    case (sel)
      SEL_TBL1: nxt = tgt1;
      SEL_TBL2: nxt = tgt2;
      SEL_STEP: nxt = step_of(cur);
      default:  nxt = '0;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [useq_pkg::OP_W-1:0]  opcode,
  output logic [useq_pkg::ST_W-1:0]  state_num,
  output logic [1:0]                 sel_dbg
);
  localparam int NUM_TBL = 2;

  ustate_t state_q;
  ustate_t state_d;
  sel_e    sel_w;
  ustate_t tgt_w [1:NUM_TBL];

  useq_ctl_field u_field (
    .cur (state_q),
    .sel (sel_w)
  );

  for (genvar g = 1; g <= NUM_TBL; g++) begin : g_tbl
    useq_dispatch #(.TABLE_SEL(g)) u_disp (
      .op     (opcode),
      .target (tgt_w[g])
    );
  end

  useq_next_mux u_mux (
    .sel  (sel_w),
    .cur  (state_q),
    .tgt1 (tgt_w[1]),
    .tgt2 (tgt_w[2]),
    .nxt  (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign state_num = state_q;
  assign sel_dbg   = sel_w;

  a_r3_step_adds_one: assert property (@(posedge clk) disable iff (rst)
    sel_w == SEL_STEP |=> state_q == $past(state_q) + ustate_t'(1));

  a_r4_restart_zero: assert property (@(posedge clk) disable iff (rst)
    sel_w == SEL_RESTART |=> state_q == '0);

  a_r5_first_targets: assert property (@(posedge clk) disable iff (rst)
    sel_w == SEL_TBL1 |=> state_q inside {4'd0, 4'd2, 4'd6, 4'd8, 4'd9});

  a_r6_second_targets: assert property (@(posedge clk) disable iff (rst)
    sel_w == SEL_TBL2 |=> state_q inside {4'd0, 4'd3, 4'd5});

  a_r2_reachable: assert property (@(posedge clk) disable iff (rst)
    state_q <= 4'd9);
endmodule

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] state_num;
  logic [1:0] sel_dbg;

  int tests = 0;
  int fails = 0;
  int model = 0;

  useq_sequencer uut (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .state_num (state_num),
    .sel_dbg   (sel_dbg)
  );

  always #2 clk = ~clk;

  function automatic int exp_sel(int s);
    if (s == 1) return 1;
    if (s == 2) return 2;
    if (s == 0 || s == 3 || s == 6) return 3;
    return 0;
  endfunction

  function automatic int exp_next(int s, int op);
    int k = exp_sel(s);
    if (k == 3) return (s + 1) % 16;
    if (k == 0) return 0;
    if (k == 1) begin
      if (op == 6'o00) return 6;
      if (op == 6'o02) return 9;
      if (op == 6'o04) return 8;
      if (op == 6'o43 || op == 6'o53) return 2;
      return 0;
    end
    if (op == 6'o43) return 3;
    if (op == 6'o53) return 5;
    return 0;
  endfunction

  function automatic string tag_of(int s);
    case (exp_sel(s))
      0: return "R4 R9";
      1: return "R5 R7";
      2: return "R6 R7";
      default: return "R3 R9";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; opcode = 6'o53;
    @(negedge clk); rst = 1'b0;
    check("R1", state_num, 0);
    model = 0;
  endtask

  task automatic run_seq(logic [5:0] op, int n, logic [23:0] exp);
    do_reset();
    for (int i = 0; i < n; i++) begin
      check("R8", state_num, exp[23 - 4*i -: 4]);
      opcode = op;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    check("R2", sel_dbg, 3);
    run_seq(6'o00, 5, 24'h016700);
    run_seq(6'o43, 6, 24'h012340);
    run_seq(6'o53, 5, 24'h012500);
    run_seq(6'o04, 4, 24'h018000);
    run_seq(6'o02, 4, 24'h019000);
    run_seq(6'o17, 3, 24'h010000);
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic [5:0] op;
      check("R2", sel_dbg, exp_sel(model));
      pick = $urandom_range(0, 9);
      case (pick)
        0: op = 6'o00;
        1: op = 6'o02;
        2: op = 6'o04;
        3, 4: op = 6'o43;
        5, 6: op = 6'o53;
        default: op = 6'($urandom);
      endcase
      opcode = op;
      rst = ($urandom_range(0, 49) == 0);
      @(negedge clk);
      if (rst) begin
        model = 0;
        check("R1", state_num, 0);
      end else begin
        string t = tag_of(model);
        model = exp_next(model, op);
        check(t, state_num, model);
      end
    end
    rst = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule